// File: doc/BRIEF.md
# Flash Programming Register Front-End

This block sits on a CPU special-function-register bus and collects the data for a flash program operation. The bus carries 8-bit and 16-bit accesses, and a two-bit byte enable selects the lanes. Software sets a segment register first. It then fills two 16-bit data registers, and the write to one trigger byte launches a program request toward the flash array. The segment value picks the target region, and that choice sets which byte is the trigger and how many data bytes are used. A program-memory segment uses four bytes, and its trigger is the high byte of the second data register. The data-flash segment uses one byte, and its trigger is the low byte of the first data register.

When an operation starts, the block issues a one-cycle request that carries the segment, a length flag and 32 bits of data. It then holds a busy bit in a readable status register until the flash side answers with a done pulse. While the flash side works, the CPU can keep running and poll the status register. While busy is set, the data and segment registers are locked.

Top module: `flash_pgm_front`

## Requirements
- R1: After reset, both data registers read 0xFFFF, the segment register reads 0x0000, status bit 0 (busy) reads 0 and prog_req is low.
- R2: The registers are decoded on word addresses: data register A at BASE_ADDR (default 0xF092), data register B at BASE_ADDR+2, segment at BASE_ADDR+4 and status at BASE_ADDR+6, with address bit 0 ignored. bus_be[0] writes bits 7:0 and bus_be[1] writes bits 15:8. The segment register holds SEG_W bits in lane 0. Reads are combinational and return the stored values, status bit 0 is busy, and an unmapped address reads 0.
- R3: When the segment is not DF_SEG (program memory), a write with bus_be[1] set to data register B starts an operation. One cycle later, prog_req is high with prog_len4=1 and prog_data={regB,regA}, which includes the byte just written.
- R4: A 16-bit word write to data register B in program-memory mode produces exactly one request pulse.
- R5: In program-memory mode, writes to data register A, low-byte-only writes to data register B, and writes to the segment register, to status or to unmapped addresses start no operation.
- R6: When the segment equals DF_SEG (data flash), a write with bus_be[0] set to data register A starts an operation. One cycle later, prog_req is high with prog_len4=0 and prog_data={24'hFFFFFF, regA[7:0]}.
- R7: In data-flash mode, writes to the high byte of data register A and writes to data register B start no operation.
- R8: Busy reads 1 from the cycle after a trigger write. It reads 0 from the cycle after a prog_done pulse.
- R9: While busy is set, writes to the data and segment registers are ignored and no trigger write starts a second operation.
- R10: A prog_done pulse while idle has no effect on the status or the registers.
- R11: prog_req is high for exactly one cycle per operation, and prog_seg shows the segment that chose the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 2 | Byte lane enables (bit 0 = low byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| prog_req | output | 1 | One-cycle program request |
| prog_seg | output | SEG_W | Segment of the request |
| prog_len4 | output | 1 | 1 = four bytes, 0 = one byte |
| prog_data | output | 32 | Program data, first byte in bits 7:0 |
| prog_done | input | 1 | Flash side finished the operation |

## Verification
The hardest case to reach is a write that arrives while an operation is still in flight, because it should change nothing. This matters most when that write would otherwise be a valid trigger for the current mode, or when it tries to change the segment that is in use. The random stimulus delays prog_done by a random number of accesses, so many register and trigger writes fall into the busy window. Directed steps also switch the segment between the two modes and aim the trigger byte of the wrong mode at the block.

// File: rtl/fpr_pkg.sv
// Shared types for the flash programming register front-end.
// Assumes a word-organised register window of four 16-bit slots.
package fpr_pkg;
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DA   = 3'd1,
        SEL_DB   = 3'd2,
        SEL_SEG  = 3'd3,
        SEL_STAT = 3'd4
    } fpr_sel_e;
endpackage

// File: rtl/fpr_decode.sv
// Address decoder: maps a byte address to one of the four register slots.
// Assumes BASE_ADDR is even; address bit 0 is ignored (lanes come from byte enables).
module fpr_decode
    import fpr_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'hF092
) (
    input  logic [ADDR_W-1:0] addr,
    output fpr_sel_e          sel
);
    localparam logic [ADDR_W-2:0] BASE_W = BASE_ADDR[ADDR_W-1:1];

    // Compare the word address against each slot.
    always_comb begin
        sel = SEL_NONE;
        if (addr[ADDR_W-1:1] == BASE_W)            sel = SEL_DA;
        else if (addr[ADDR_W-1:1] == BASE_W + 1'b1) sel = SEL_DB;
        else if (addr[ADDR_W-1:1] == BASE_W + 2'd2) sel = SEL_SEG;
        else if (addr[ADDR_W-1:1] == BASE_W + 2'd3) sel = SEL_STAT;
    end
endmodule

// File: rtl/fpr_regs.sv
// Data and segment register file with per-lane writes.
// Assumes wr_en is already gated by the busy lockout; busy is only used by the check.
module fpr_regs
    import fpr_pkg::*;
#(
    parameter int SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             busy,
    input  fpr_sel_e         sel,
    input  logic [1:0]       be,
    input  logic [15:0]      wdata,
    output logic [15:0]      reg_a,
    output logic [15:0]      reg_b,
    output logic [SEG_W-1:0] seg
);
    localparam int LANES = 2;

    // Byte-lane writes into the two data registers.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_a[l*8 +: 8] <= 8'hFF;
                reg_b[l*8 +: 8] <= 8'hFF;
            end else if (wr_en && be[l]) begin
                if (sel == SEL_DA) reg_a[l*8 +: 8] <= wdata[l*8 +: 8];
                if (sel == SEL_DB) reg_b[l*8 +: 8] <= wdata[l*8 +: 8];
            end
        end
    end

    // Segment register lives in the low lane.
    always_ff @(posedge clk) begin
        if (!rst_n)                                seg <= '0;
        else if (wr_en && be[0] && sel == SEL_SEG) seg <= wdata[SEG_W-1:0];
    end

    // R9: nothing changes the registers while an operation is in flight.
    p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(reg_a) && $stable(reg_b) && $stable(seg)));
endmodule

// File: rtl/fpr_ctrl.sv
// Trigger detection and busy tracking.
// The trigger byte depends on the mode that the current segment selects.
// Assumes prog_done is a pulse from the flash side.
module fpr_ctrl
    import fpr_pkg::*;
#(
    parameter int              SEG_W  = 8,
    parameter logic [SEG_W-1:0] DF_SEG = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  fpr_sel_e         sel,
    input  logic [1:0]       be,
    input  logic [SEG_W-1:0] seg,
    input  logic             done,
    output logic             busy,
    output logic             req,
    output logic             len4
);
    logic is_df;
    logic trig;

    // Pick the trigger byte for the current mode; block it while busy.
    always_comb begin
        is_df = (seg == DF_SEG);
        if (is_df) trig = bus_wr && !busy && (sel == SEL_DA) && be[0];
        else       trig = bus_wr && !busy && (sel == SEL_DB) && be[1];
    end

    // Busy flag: set by a trigger, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy <= 1'b0;
        else if (trig) busy <= 1'b1;
        else if (done) busy <= 1'b0;
    end

    // One-cycle request pulse and the length flag latched at the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            len4 <= 1'b0;
        end else begin
            req <= trig;
            if (trig) len4 <= !is_df;
        end
    end

    p_trig_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (req && busy));
    p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    p_req_has_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> busy);
    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> !busy);
    p_no_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !req);
    p_busy_from_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> req);
endmodule

// File: rtl/flash_pgm_front.sv
// Flash programming register front-end: bus-side registers, trigger and request.
// Assumes one write per bus_wr cycle and combinational reads with no side effects.
module flash_pgm_front
    import fpr_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter logic [15:0]      BASE_ADDR = 16'hF092,
    parameter int               SEG_W     = 8,
    parameter logic [SEG_W-1:0] DF_SEG    = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              prog_req,
    output logic [SEG_W-1:0]  prog_seg,
    output logic              prog_len4,
    output logic [31:0]       prog_data,
    input  logic              prog_done
);
    fpr_sel_e         sel;
    logic             busy;
    logic [15:0]      reg_a;
    logic [15:0]      reg_b;
    logic [SEG_W-1:0] seg;

    fpr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    fpr_regs #(.SEG_W(SEG_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && !busy),
        .busy  (busy),
        .sel   (sel),
        .be    (bus_be),
        .wdata (bus_wdata),
        .reg_a (reg_a),
        .reg_b (reg_b),
        .seg   (seg)
    );

    fpr_ctrl #(.SEG_W(SEG_W), .DF_SEG(DF_SEG)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_wr (bus_wr),
        .sel    (sel),
        .be     (bus_be),
        .seg    (seg),
        .done   (prog_done),
        .busy   (busy),
        .req    (prog_req),
        .len4   (prog_len4)
    );

    // Read mux for the four slots.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DA:   bus_rdata = reg_a;
            SEL_DB:   bus_rdata = reg_b;
            SEL_SEG:  bus_rdata[SEG_W-1:0] = seg;
            SEL_STAT: bus_rdata[0] = busy;
            default:  bus_rdata = '0;
        endcase
    end

    // Request payload: the segment stays locked, so it is stable for the request.
    always_comb begin
        prog_seg  = seg;
        prog_data = prog_len4 ? {reg_b, reg_a} : {24'hFFFFFF, reg_a[7:0]};
    end

    p_len_matches_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> (prog_len4 == (prog_seg != DF_SEG)));
endmodule

// File: tb/flash_pgm_front_bench.sv
module flash_pgm_front_bench;
    localparam logic [15:0] A_DA   = 16'hF092;
    localparam logic [15:0] A_DB   = 16'hF094;
    localparam logic [15:0] A_SEG  = 16'hF096;
    localparam logic [15:0] A_STAT = 16'hF098;
    localparam logic [7:0]  DF     = 8'h0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        prog_req;
    logic [7:0]  prog_seg;
    logic        prog_len4;
    logic [31:0] prog_data;
    logic        prog_done = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [15:0] m_a = 16'hFFFF, m_b = 16'hFFFF;
    logic [7:0]  m_seg = '0;
    logic        m_busy = 1'b0;

    always #10 clk = ~clk;

    flash_pgm_front u_flash_pgm_front (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prog_req(prog_req), .prog_seg(prog_seg), .prog_len4(prog_len4),
        .prog_data(prog_data), .prog_done(prog_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [15:0] a);
        case ({a[15:1], 1'b0})
            A_DA:    return m_a;
            A_DB:    return m_b;
            A_SEG:   return {8'h00, m_seg};
            A_STAT:  return {15'h0, m_busy};
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_data(input bit len4);
        return len4 ? {m_b, m_a} : {24'hFFFFFF, m_a[7:0]};
    endfunction

    task automatic rd(input logic [15:0] a, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp_read(a), tag, {16'h0, bus_rdata}, {16'h0, exp_read(a)});
    endtask

    // Write at a negedge; results checked at the following negedge.
    task automatic wr(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
        bit df, trig, was_busy;
        string tag;
        df = (m_seg == DF);
        was_busy = m_busy;
        trig = !m_busy && (df ? (a[15:1] == A_DA[15:1] && be[0]) : (a[15:1] == A_DB[15:1] && be[1]));
        if (!m_busy) begin
            if (a[15:1] == A_DA[15:1]) begin
                if (be[0]) m_a[7:0] = d[7:0];
                if (be[1]) m_a[15:8] = d[15:8];
            end
            if (a[15:1] == A_DB[15:1]) begin
                if (be[0]) m_b[7:0] = d[7:0];
                if (be[1]) m_b[15:8] = d[15:8];
            end
            if (a[15:1] == A_SEG[15:1] && be[0]) m_seg = d[7:0];
        end
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (trig) begin
            m_busy = 1'b1;
            tag = df ? "R6" : "R3";
            chk(prog_req == 1'b1, tag, {31'h0, prog_req}, 32'h1);
            chk(prog_len4 == !df, tag, {31'h0, prog_len4}, {31'h0, !df});
            chk(prog_data == exp_data(!df), tag, prog_data, exp_data(!df));
            chk(prog_seg == m_seg, "R11", {24'h0, prog_seg}, {24'h0, m_seg});
            @(negedge clk);
            chk(prog_req == 1'b0, "R11 R4", {31'h0, prog_req}, 32'h0);
        end else begin
            tag = was_busy ? "R9" : (df ? "R7" : "R5");
            chk(prog_req == 1'b0, tag, {31'h0, prog_req}, 32'h0);
        end
        rd(A_STAT, "R8");
    endtask

    task automatic done_pulse(input string tag);
        prog_done = 1'b1;
        @(negedge clk);
        prog_done = 1'b0;
        m_busy = 1'b0;
        rd(A_STAT, tag);
        rd(A_DA, tag);
        rd(A_DB, tag);
        rd(A_SEG, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [15:0] d;
        logic [1:0]  be;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(prog_req == 1'b0, "R1", {31'h0, prog_req}, 32'h0);
        rd(A_DA, "R1"); rd(A_DB, "R1"); rd(A_SEG, "R1"); rd(A_STAT, "R1");
        rd(16'hF090, "R2");
        // R2 lane writes, R5 non-trigger writes in program mode
        wr(A_DA, 2'b11, 16'h1234); rd(A_DA, "R2");
        wr(A_DA + 16'd1, 2'b10, 16'hAB00); rd(A_DA, "R2");
        wr(A_DB, 2'b01, 16'h0056); rd(A_DB, "R5");
        wr(A_STAT, 2'b11, 16'hFFFF); rd(A_STAT, "R5");
        // R3 high-byte trigger
        wr(A_DB + 16'd1, 2'b10, 16'h7800);
        // R9 writes during busy ignored, no second request
        wr(A_DB, 2'b11, 16'hDEAD);
        wr(A_SEG, 2'b01, {8'h0, DF});
        wr(A_DA, 2'b11, 16'h0000);
        rd(A_DB, "R9"); rd(A_SEG, "R9");
        done_pulse("R8");
        // R10 done while idle
        done_pulse("R10");
        // R4 word write trigger
        wr(A_DA, 2'b11, 16'hC0DE);
        wr(A_DB, 2'b11, 16'hBEEF);
        done_pulse("R8");
        // R7 data-flash mode: wrong bytes start nothing, R6 low byte triggers
        wr(A_SEG, 2'b01, {8'h0, DF}); rd(A_SEG, "R2");
        wr(A_DB, 2'b11, 16'h5555);
        wr(A_DA, 2'b10, 16'h9900);
        wr(A_DA, 2'b01, 16'h003C);
        done_pulse("R8");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            case ($urandom % 6)
                0: a = A_DA;
                1: a = A_DB;
                2: a = A_SEG;
                3: a = A_STAT;
                4: a = 16'hF0A0;
                default: a = ($urandom % 2) ? A_DB : A_DA;
            endcase
            a = a | 16'($urandom % 2);
            be = 2'(($urandom % 3) + 1);
            d = 16'($urandom);
            if (a[15:1] == A_SEG[15:1] && ($urandom % 2)) d = {8'h0, DF};
            wr(a, be, d);
            rd((($urandom % 2) ? A_DA : A_DB), "R2");
            if (m_busy && ($urandom % 4 == 0)) done_pulse("R8");
            if (!m_busy && ($urandom % 20 == 0)) done_pulse("R10");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule